// File: doc/BRIEF.md
# Dual-Reload PWM Capture Timer

A 16-bit down-counter with two companion 16-bit registers, A and B, that can run as a free-standing PWM generator, as a counter of external pulses, or as a two-channel time-stamp unit. Software sets the mode, the run bit and the interrupt enables through a small word-wide register bus. The bus also gives access to the counter and both companion registers. An instruction-cycle tick input paces the counter in the PWM and capture modes.

In PWM mode the counter alternately reloads from A and from B each time it passes zero, and pin A toggles at each reload. The high and low phase lengths are therefore set independently and repeat with no further software action. In event mode each rising edge on pin A counts down by one. In capture mode the counter free-runs, and rising edges on pin A or pin B latch the current count into A or B. Two pending flags with their own enables feed one interrupt line.

Top module: `dual_reload_timer`

## Requirements
- R1: After a synchronous reset the control word reads 0 (idle mode, stopped, flags and enables clear), `irq` is low and `pin_a_oe` and `pin_a_out` are low. The counter and registers A and B are not reset.
- R2: The counter only changes while the run bit is set. In PWM and capture modes it steps down by one on each clock with `tick_en` high and holds while `tick_en` is low.
- R3: In PWM mode the first zero-crossing after start reloads from A, and later ones alternate B, A, B and so on. The reload takes the place of a step, so a phase lasts reload value + 1 ticks.
- R4: In PWM mode `pin_a_oe` is high and `pin_a_out` starts low and inverts at every reload. Outside running PWM the output returns low and the next start begins again with A. `pin_a_oe` is low in every other mode.
- R5: In event mode the counter steps down once per rising edge of `pin_a_in`, after a two-flop synchronizer, on the third clock edge after the pin rises. A step at zero reloads from A and sets pending flag A.
- R6: In capture mode a synchronized rising edge of `pin_a_in` copies the count held before that edge into register A and sets pending flag A. A rising edge of `pin_b_in` does the same with register B and pending flag B.
- R7: Pending flag B is set only by a capture-mode edge on pin B. Pin B edges in other modes leave it clear.
- R8: In PWM mode pending flag A is set on each reload from A and not on a reload from B.
- R9: A control write of 0 to a pending bit clears it, and a write of 1 leaves it unchanged. A hardware set in the same cycle as a clearing write wins.
- R10: `irq` is high exactly when (pending A and enable A) or (pending B and enable B).
- R11: Bus map: address 0 is the counter, 1 is register A, 2 is register B and 3 is the control word. Control bits are [7:5] mode (100 PWM, 001 event, 010 capture, other values idle), [4] run, [3] pending A, [2] enable A, [1] pending B and [0] enable B. The upper bits read 0. `bus_rdata` is a combinational read of `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Instruction-cycle tick that paces PWM and capture counting |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for read and write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register |
| pin_a_in | input | 1 | Pin A input level (event and capture source) |
| pin_b_in | input | 1 | Pin B input level (capture source) |
| pin_a_out | output | 1 | Pin A PWM output level |
| pin_a_oe | output | 1 | Pin A output enable, high in PWM mode |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch every cycle for these properties: the PWM count steps by one, the counter holds in event mode when no edge arrives, and the capture registers receive the previous count. They also check that the PWM output changes only at a zero-crossing, that a flag rises only on a hardware set and falls only on a clearing write, that pending B appears only in capture mode, and that the interrupt stays low with both enables off. The A, B, A reload order, the exact phase lengths, the three-edge latency from pin to count and the set-beats-clear race show up only in the bench scenarios, which check register and pin values at chosen cycles against values worked out from the requirements.

// File: rtl/drt_pkg.sv
package drt_pkg;

    localparam int unsigned ADDR_W   = 2;
    localparam int unsigned CTRL_W   = 8;
    localparam int unsigned NUM_PINS = 2;

    localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_REG_A = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_REG_B = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd3;

    localparam int unsigned PIN_A = 0;
    localparam int unsigned PIN_B = 1;

    typedef enum logic [2:0] {
        MODE_IDLE  = 3'b000,
        MODE_EVENT = 3'b001,
        MODE_CAPT  = 3'b010,
        MODE_PWM   = 3'b100
    } mode_e;

    // Control word, most significant field first
    typedef struct packed {
        logic [2:0] mode;
        logic       run;
        logic       pend_a;
        logic       en_a;
        logic       pend_b;
        logic       en_b;
    } ctrl_t;

    typedef struct packed {
        logic set_a;
        logic set_b;
    } flag_set_t;

    function automatic mode_e decode_mode(input logic [2:0] raw);
        case (raw)
            3'b100:  return MODE_PWM;
            3'b001:  return MODE_EVENT;
            3'b010:  return MODE_CAPT;
            default: return MODE_IDLE;
        endcase
    endfunction

    function automatic logic irq_of(input ctrl_t c);
        return (c.pend_a & c.en_a) | (c.pend_b & c.en_b);
    endfunction

endpackage

// File: rtl/drt_edge_sync.sv
module drt_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], din};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~last_q;

    // R5: a held-high pin yields a single-cycle pulse
    p_rise_single_r5: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/drt_ctrl_reg.sv
module drt_ctrl_reg
    import drt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [CTRL_W-1:0] wdata,
    input  flag_set_t         hw_set,
    output ctrl_t             ctrl
);
    ctrl_t ctrl_q;
    ctrl_t ctrl_d;
    ctrl_t wr_view;

    assign wr_view = ctrl_t'(wdata);

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.mode   = wr_view.mode;
            ctrl_d.run    = wr_view.run;
            ctrl_d.en_a   = wr_view.en_a;
            ctrl_d.en_b   = wr_view.en_b;
            ctrl_d.pend_a = ctrl_q.pend_a & wr_view.pend_a;
            ctrl_d.pend_b = ctrl_q.pend_b & wr_view.pend_b;
        end
        if (hw_set.set_a) ctrl_d.pend_a = 1'b1;
        if (hw_set.set_b) ctrl_d.pend_b = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

    // R9: flags rise only on a hardware set
    p_pend_a_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.pend_a) |-> $past(hw_set.set_a));
    p_pend_b_rise_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.pend_b) |-> $past(hw_set.set_b));
    // R9: flags fall only on a clearing write without a competing set
    p_pend_a_fall_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q.pend_a) |-> $past(wr_ctrl && !wdata[3] && !hw_set.set_a));
    p_pend_b_fall_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q.pend_b) |-> $past(wr_ctrl && !wdata[1] && !hw_set.set_b));

endmodule

// File: rtl/drt_count_core.sv
module drt_count_core
    import drt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  mode_e            mode,
    input  logic             run,
    input  logic             edge_a,
    input  logic             edge_b,
    input  logic             wr_cnt,
    input  logic             wr_ra,
    input  logic             wr_rb,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] ra_o,
    output logic [CNT_W-1:0] rb_o,
    output flag_set_t        hw_set,
    output logic             pwm_level
);
    logic [CNT_W-1:0] cnt_q, ra_q, rb_q;
    logic [CNT_W-1:0] cnt_d, ra_d, rb_d, reload_val;
    logic             use_b_q, use_b_d, level_q, level_d;
    logic             pwm_act, evt_act, cap_act;
    logic             at_zero, step, uflow;
    logic             cap_a_hit, cap_b_hit;

    assign pwm_act = run && (mode == MODE_PWM);
    assign evt_act = run && (mode == MODE_EVENT);
    assign cap_act = run && (mode == MODE_CAPT);
    assign at_zero = (cnt_q == '0);

    assign step  = (pwm_act && tick_en) || (evt_act && edge_a) || (cap_act && tick_en);
    assign uflow = step && at_zero && (pwm_act || evt_act);

    assign reload_val = (pwm_act && use_b_q) ? rb_q : ra_q;
    assign cap_a_hit  = cap_act && edge_a;
    assign cap_b_hit  = cap_act && edge_b;

    always_comb begin
        cnt_d = cnt_q;
        if (wr_cnt)     cnt_d = wdata;
        else if (uflow) cnt_d = reload_val;
        else if (step)  cnt_d = cnt_q - 1'b1;
    end

    always_comb begin
        ra_d = ra_q;
        if (cap_a_hit)  ra_d = cnt_q;
        else if (wr_ra) ra_d = wdata;
        rb_d = rb_q;
        if (cap_b_hit)  rb_d = cnt_q;
        else if (wr_rb) rb_d = wdata;
    end

    always_comb begin
        use_b_d = use_b_q;
        level_d = level_q;
        if (!pwm_act) begin
            use_b_d = 1'b0;
            level_d = 1'b0;
        end else if (uflow) begin
            use_b_d = ~use_b_q;
            level_d = ~level_q;
        end
    end

    // Counter and companion registers have no reset value
    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
        ra_q  <= ra_d;
        rb_q  <= rb_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            use_b_q <= 1'b0;
            level_q <= 1'b0;
        end else begin
            use_b_q <= use_b_d;
            level_q <= level_d;
        end
    end

    assign hw_set.set_a = (uflow && !(pwm_act && use_b_q)) || cap_a_hit;
    assign hw_set.set_b = cap_b_hit;

    assign cnt_o     = cnt_q;
    assign ra_o      = ra_q;
    assign rb_o      = rb_q;
    assign pwm_level = level_q;

    // R2: running PWM steps by exactly one per tick away from zero
    p_pwm_step_r2: assert property (@(posedge clk) disable iff (rst)
        $past(pwm_act && tick_en && !at_zero && !wr_cnt) |-> cnt_q == $past(cnt_q) - 1'b1);
    // R2: a stopped counter holds without a bus write
    p_stopped_hold_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!run && !wr_cnt) |-> $stable(cnt_q));
    // R4: output changes inside PWM only at a zero-crossing
    p_level_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(pwm_act) && pwm_act && level_q != $past(level_q)) |-> $past(tick_en && at_zero));
    // R4: leaving PWM drops the output on the next cycle
    p_level_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !pwm_act |=> !level_q);
    // R5: event counting ignores cycles without a pin edge
    p_event_hold_r5: assert property (@(posedge clk) disable iff (rst)
        $past(evt_act && !edge_a && !wr_cnt) |-> $stable(cnt_q));
    // R6: captures take the prior count
    p_capture_a_r6: assert property (@(posedge clk) disable iff (rst)
        $past(cap_a_hit) |-> ra_q == $past(cnt_q));
    p_capture_b_r6: assert property (@(posedge clk) disable iff (rst)
        $past(cap_b_hit) |-> rb_q == $past(cnt_q));

endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
    import drt_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              pin_a_in,
    input  logic              pin_b_in,
    output logic              pin_a_out,
    output logic              pin_a_oe,
    output logic              irq
);
    localparam int unsigned PAD_W = CNT_W - CTRL_W;

    logic [NUM_PINS-1:0] pin_lvl;
    logic [NUM_PINS-1:0] pin_rise;
    ctrl_t               ctrl;
    mode_e               mode;
    flag_set_t           hw_set;
    logic [CNT_W-1:0]    cnt, reg_a, reg_b;
    logic                wr_cnt, wr_ra, wr_rb, wr_ctrl;

    assign pin_lvl[PIN_A] = pin_a_in;
    assign pin_lvl[PIN_B] = pin_b_in;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_sync
        drt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (pin_lvl[g]),
            .rise (pin_rise[g])
        );
    end

    assign wr_cnt  = bus_we && (bus_addr == ADDR_COUNT);
    assign wr_ra   = bus_we && (bus_addr == ADDR_REG_A);
    assign wr_rb   = bus_we && (bus_addr == ADDR_REG_B);
    assign wr_ctrl = bus_we && (bus_addr == ADDR_CTRL);

    drt_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wdata   (bus_wdata[CTRL_W-1:0]),
        .hw_set  (hw_set),
        .ctrl    (ctrl)
    );

    assign mode = decode_mode(ctrl.mode);

    drt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .mode      (mode),
        .run       (ctrl.run),
        .edge_a    (pin_rise[PIN_A]),
        .edge_b    (pin_rise[PIN_B]),
        .wr_cnt    (wr_cnt),
        .wr_ra     (wr_ra),
        .wr_rb     (wr_rb),
        .wdata     (bus_wdata),
        .cnt_o     (cnt),
        .ra_o      (reg_a),
        .rb_o      (reg_b),
        .hw_set    (hw_set),
        .pwm_level (pin_a_out)
    );

    always_comb begin
        case (bus_addr)
            ADDR_COUNT: bus_rdata = cnt;
            ADDR_REG_A: bus_rdata = reg_a;
            ADDR_REG_B: bus_rdata = reg_b;
            default:    bus_rdata = {{PAD_W{1'b0}}, ctrl};
        endcase
    end

    assign pin_a_oe = (mode == MODE_PWM);
    assign irq      = irq_of(ctrl);

    // R7: pending B appears only while capture mode runs
    p_pend_b_capture_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.pend_b) |-> $past(ctrl.run && mode == MODE_CAPT));
    // R10: no interrupt with both enables off
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.en_a && !ctrl.en_b) |-> !irq);
    // R4: PWM output only driven in PWM mode
    p_out_needs_oe_r4: assert property (@(posedge clk) disable iff (rst)
        (pin_a_out && $past(pin_a_out)) |-> $past(pin_a_oe));

endmodule

// File: tb/dual_reload_timer_test.sv
module dual_reload_timer_test;

    localparam int KIND_RD  = 0;
    localparam int KIND_OUT = 1;
    localparam int KIND_OE  = 2;
    localparam int KIND_IRQ = 3;

    typedef struct {
        int          kind;
        logic [15:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pin_a_in = 1'b0;
    logic        pin_b_in = 1'b0;
    logic        pin_a_out, pin_a_oe, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    item_t sb_q[$];
    event  sb_ev, sb_done;

    always #4 clk = ~clk;

    dual_reload_timer uut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_a_in  (pin_a_in),
        .pin_b_in  (pin_b_in),
        .pin_a_out (pin_a_out),
        .pin_a_oe  (pin_a_oe),
        .irq       (irq)
    );

    // Monitor: pops expected items and compares against the ports
    initial begin : monitor
        item_t       cur;
        logic [15:0] act;
        forever begin
            @(sb_ev);
            #1;
            cur = sb_q.pop_front();
            case (cur.kind)
                KIND_RD:  act = bus_rdata;
                KIND_OUT: act = {15'd0, pin_a_out};
                KIND_OE:  act = {15'd0, pin_a_oe};
                default:  act = {15'd0, irq};
            endcase
            checks++;
            if (act !== cur.exp) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", cur.tag, act, cur.exp);
            end
            -> sb_done;
        end
    end

    task automatic expect_item(input int kind, input logic [1:0] addr,
                               input logic [15:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        bus_addr = addr;
        sb_q.push_back(it);
        -> sb_ev;
        @(sb_done);
    endtask

    task automatic expect_reg(input logic [1:0] addr, input logic [15:0] exp, input string tag);
        expect_item(KIND_RD, addr, exp, tag);
    endtask

    task automatic expect_pin(input int kind, input logic v, input string tag);
        expect_item(kind, 2'd0, {15'd0, v}, tag);
    endtask

    task automatic next_cycle();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] addr, input logic [15:0] data);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = addr;
        bus_wdata = data;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic pulse(input bit on_b);
        @(negedge clk);
        if (on_b) pin_b_in = 1'b1; else pin_a_in = 1'b1;
        repeat (3) @(negedge clk);
        if (on_b) pin_b_in = 1'b0; else pin_a_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        next_cycle();
        expect_reg(2'd3, 16'h0000, "R1 control after reset");
        expect_pin(KIND_IRQ, 1'b0, "R1 irq after reset");
        expect_pin(KIND_OE, 1'b0, "R1 oe after reset");
        expect_pin(KIND_OUT, 1'b0, "R1 out after reset");

        // PWM: A=3, B=1, start from zero, enable A (R3 R4 R8 R11)
        bus_write(2'd1, 16'd3);
        bus_write(2'd2, 16'd1);
        bus_write(2'd0, 16'd0);
        bus_write(2'd3, 16'h0094);
        next_cycle();
        expect_pin(KIND_OUT, 1'b0, "R4 output low before first reload");
        expect_pin(KIND_OE, 1'b1, "R4 oe high in PWM");
        next_cycle();
        expect_pin(KIND_OUT, 1'b1, "R4 output toggles at first reload");
        expect_reg(2'd0, 16'd3, "R3 first reload from A");
        expect_pin(KIND_IRQ, 1'b1, "R8 A reload sets pending A");
        next_cycle(); next_cycle(); next_cycle();
        expect_reg(2'd0, 16'd0, "R2 PWM steps once per tick");
        next_cycle();
        expect_reg(2'd0, 16'd1, "R3 second reload from B");
        expect_pin(KIND_OUT, 1'b0, "R3 high phase lasts A+1 ticks");
        expect_reg(2'd3, 16'h0094 | 16'h0008, "R11 control word with pending A");
        next_cycle(); next_cycle();
        expect_reg(2'd0, 16'd3, "R3 third reload from A again");
        expect_pin(KIND_OUT, 1'b1, "R3 low phase lasts B+1 ticks");

        // Stop: flags cleared by write of 0, output returns low (R4 R9)
        bus_write(2'd3, 16'h0000);
        next_cycle(); next_cycle();
        expect_pin(KIND_OUT, 1'b0, "R4 output low after stop");
        expect_pin(KIND_OE, 1'b0, "R4 oe low when idle");
        expect_reg(2'd3, 16'h0000, "R9 write of 0 clears pending A");
        expect_pin(KIND_IRQ, 1'b0, "R10 irq low after clear");
        expect_reg(2'd0, 16'd1, "R2 stopped counter value");
        next_cycle(); next_cycle(); next_cycle();
        expect_reg(2'd0, 16'd1, "R2 stopped counter holds");

        // Writing 1 to a pending bit has no effect (R9)
        bus_write(2'd3, 16'h000C);
        next_cycle();
        expect_reg(2'd3, 16'h0004, "R9 write of 1 does not set pending");
        expect_pin(KIND_IRQ, 1'b0, "R10 irq low without pending");

        // Event mode, ticks off (R5 R7)
        tick_en = 1'b0;
        bus_write(2'd1, 16'd5);
        bus_write(2'd0, 16'd2);
        bus_write(2'd3, 16'h0034);
        pulse(1'b0);
        expect_reg(2'd0, 16'd1, "R5 first pin edge counts down");
        pulse(1'b0);
        expect_reg(2'd0, 16'd0, "R5 second pin edge counts down");
        pulse(1'b1);
        expect_reg(2'd3, 16'h0034, "R7 pin B edge ignored outside capture");
        expect_reg(2'd0, 16'd0, "R7 pin B edge leaves count");
        pulse(1'b0);
        expect_reg(2'd0, 16'd5, "R5 edge at zero reloads from A");
        expect_reg(2'd3, 16'h003C, "R5 reload sets pending A");
        expect_pin(KIND_IRQ, 1'b1, "R10 irq with pending A enabled");

        // Set beats clear in the same cycle (R9)
        bus_write(2'd0, 16'd0);
        @(negedge clk) pin_a_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 2'd3; bus_wdata = 16'h0034;
        @(posedge clk);
        #1 bus_we = 1'b0;
        next_cycle();
        expect_reg(2'd3, 16'h003C, "R9 hardware set wins over clear");
        expect_reg(2'd0, 16'd5, "R5 reload in race cycle");
        pin_a_in = 1'b0;
        repeat (3) next_cycle();
        bus_write(2'd3, 16'h0034);
        next_cycle();
        expect_reg(2'd3, 16'h0034, "R9 later clear succeeds");

        // Capture mode (R6 R2)
        tick_en = 1'b1;
        bus_write(2'd0, 16'd100);
        bus_write(2'd3, 16'h0055);
        @(negedge clk) pin_a_in = 1'b1;
        repeat (3) @(negedge clk);
        tick_en = 1'b0;
        expect_reg(2'd1, 16'd98, "R6 pin A edge captures prior count");
        expect_reg(2'd0, 16'd97, "R6 counter free-runs down");
        expect_reg(2'd3, 16'h005D, "R6 capture sets pending A");
        pin_a_in = 1'b0;
        @(negedge clk);
        expect_reg(2'd0, 16'd97, "R2 counter holds without tick");
        pin_b_in = 1'b1;
        repeat (3) @(negedge clk);
        expect_reg(2'd2, 16'd97, "R6 pin B edge captures count");
        expect_reg(2'd3, 16'h005F, "R7 capture sets pending B");
        expect_pin(KIND_OE, 1'b0, "R4 oe low in capture");
        pin_b_in = 1'b0;

        // Enables gate the interrupt (R10)
        bus_write(2'd3, 16'h005A);
        next_cycle();
        expect_reg(2'd3, 16'h005A, "R10 flags kept with enables off");
        expect_pin(KIND_IRQ, 1'b0, "R10 irq low with enables off");
        bus_write(2'd3, 16'h005B);
        next_cycle();
        expect_pin(KIND_IRQ, 1'b1, "R10 irq from pending B enabled");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule